// File: doc/BRIEF.md
# Linked-descriptor frame mover for an Ethernet MAC

The block carries frames between a MAC-facing byte stream and system memory. Each direction owns a channel that walks a chain of three-word descriptors in memory. The first word holds the buffer address, the second a control word, the third a link to the following descriptor. A single flag in the control word says who owns the descriptor. Software hands a transmit descriptor to hardware by clearing the flag, and hardware sets it again once the bytes have gone out. Software arms a receive descriptor with the flag set and the buffer capacity in the size field. Hardware clears the flag and records the stored length once the frame has landed.

Both channels share one 32-bit memory port with a request/grant handshake. A register file holds, for each channel, an enable bit, a descriptor pointer and sticky write-one-to-clear status. It also holds a shared interrupt enable and a read-only interrupt summary. A channel that meets a descriptor it does not own stops and clears its own enable bit. Software then reloads the pointer and re-enables the channel.

Top module: `ring_dma`

## Requirements
- R1: A descriptor at byte address P is read as three words: the buffer address at P, the control word at P+4 and the link at P+8. In the control word, bit 31 is the empty flag, bits 20:16 are an override field, bits 11:0 are the size, and the other bits are reserved. Buffer addresses are word aligned. Byte n of a buffer sits in lane n mod 4 (bits 8*(n mod 4)+7 down to 8*(n mod 4)) of the word at buffer + 4*(n/4).
- R2: For a transmit descriptor whose empty flag is clear and whose size S is non-zero, the channel emits buffer bytes 0..S-1 in order on tx_data. tx_last is high only with byte S-1. The channel then writes the control word back with bit 31 set and the other bits unchanged, and sets TX status bit 0 (sent).
- R3: A transmit descriptor whose empty flag is already set produces no bytes. The channel clears its TX enable bit (register 0, bit 0).
- R4: A receive descriptor whose empty flag is set takes bytes from the stream into its buffer. Every byte up to and including the one with rx_last is counted, so the trailing 4-byte check sequence is included in the length. The channel writes the control word back with bit 31 cleared, bits 30:12 unchanged and the stored length in bits 11:0. Lanes of the final partial word beyond the frame are written as zero. The channel then sets RX status bit 0 (received).
- R5: A receive descriptor whose empty flag is clear stops the receive channel. RX enable (register 3, bit 0) reads 0, rx_ready stays low and no status bit is set.
- R6: After a descriptor completes, the channel's pointer register (register 1 for TX, register 4 for RX) holds the link word. If the channel is still enabled, it processes that descriptor next.
- R7: A frame longer than the size field is cut at the size. No byte beyond the capacity is written to memory, the written-back length equals the capacity, and RX status bit 2 (overflow) is set together with bit 0.
- R8: A transmit descriptor with size 0 produces no bytes. It is still handed back with bit 31 set, the link is followed, and TX status bit 1 (underrun) is set instead of bit 0.
- R9: A memory access granted with mem_err high sets status bit 3 (bus error) of the channel that made it and clears that channel's enable bit.
- R10: Status bits are sticky. Writing a 1 to a bit of register 2 (TX status) or register 5 (RX status) clears it; writing 0 leaves it.
- R11: Register 7 reads TX sent/underrun/bus error in bits 0/1/3 and RX received/overflow/bus error in bits 4/6/7. Register 6 holds enables for the same bits. irq is high exactly when some bit is set in both registers.
- R12: Once mem_req is raised, mem_req, mem_we and mem_addr stay unchanged until a cycle with mem_gnt high. A read returns mem_rdata in that cycle.
- R13: After reset, every register reads 0, irq is low, mem_req, tx_valid and rx_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index 0..7 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Access completes in this cycle |
| mem_err | input | 1 | Granted access failed |
| mem_rdata | input | 32 | Read data, valid with mem_gnt |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of a descriptor |
| tx_ready | input | 1 | MAC accepts the transmit byte |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of a frame |
| rx_ready | output | 1 | Channel accepts a receive byte |

## Verification
The hardest case to reach is the truncation boundary. A capacity that is not a multiple of four leaves a partial word that must be flushed at the capacity, not at the frame end. The bytes that follow must then be swallowed without any memory write. A table of capacity/length pairs re-arms a single self-linked receive descriptor for each row. It drives lengths below, at and above capacities of 7, 8, 12 and 16, against a buffer prefilled with a sentinel, so a stray write or a wrong length shows up directly. Grant and transmit-ready stalls follow a fixed cyclic pattern, so handshakes wait at different points of each frame.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  localparam int WORD_W  = 32;
  localparam int SIZE_W  = 12;
  localparam int OWN_BIT = 31;
  localparam int RSEL_W  = 3;

  typedef enum logic [RSEL_W-1:0] {
    RA_TXCTL = 3'd0, RA_TXPTR = 3'd1, RA_TXST = 3'd2,
    RA_RXCTL = 3'd3, RA_RXPTR = 3'd4, RA_RXST = 3'd5,
    RA_IEN   = 3'd6, RA_IST   = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic              req;
    logic              we;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] wdata;
  } mreq_t;

  typedef struct packed {
    logic              gnt;
    logic              err;
    logic [WORD_W-1:0] rdata;
  } mrsp_t;

  // per-channel event pulses toward the register file
  typedef struct packed {
    logic              done;
    logic              flt;    // underrun (tx) or overflow (rx)
    logic              berr;
    logic              halt;
    logic              ptr_ld;
    logic [WORD_W-1:0] ptr_nx;
  } chev_t;
endpackage

// File: rtl/ring_dma_arb.sv
module ring_dma_arb
  import ring_dma_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mreq_t tx_q,
  input  mreq_t rx_q,
  output mrsp_t tx_s,
  output mrsp_t rx_s,
  output mreq_t bus_q,
  input  mrsp_t bus_s
);
  logic lock_q, lock_d, sel_q, sel_d, sel;

  // sel = 1 -> receive channel owns the port
  always_comb begin
    sel    = lock_q ? sel_q : rx_q.req;
    bus_q  = sel ? rx_q : tx_q;
    lock_d = bus_q.req & ~bus_s.gnt;
    sel_d  = sel;
    tx_s       = bus_s;
    rx_s       = bus_s;
    tx_s.gnt   = bus_s.gnt & ~sel;
    rx_s.gnt   = bus_s.gnt & sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      lock_q <= lock_d;
      sel_q  <= sel_d;
    end
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_q.req && !bus_s.gnt) |=> (bus_q.req && $stable(bus_q.addr) && $stable(bus_q.we)));
endmodule

// File: rtl/ring_dma_tx.sv
module ring_dma_tx
  import ring_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [WORD_W-1:0] ptr_i,
  output mreq_t             mq,
  input  mrsp_t             ms,
  output chev_t             ev,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready
);
  typedef enum logic [2:0] {T_IDLE, T_RBUF, T_RCTL, T_RNXT, T_FETCH, T_SEND, T_WB} tst_e;

  tst_e              st_q, st_d;
  logic [WORD_W-1:0] buf_q, buf_d, ctl_q, ctl_d, nxt_q, nxt_d, word_q, word_d;
  logic [SIZE_W-1:0] cnt_q, cnt_d;
  logic              undr_q, undr_d;
  logic [SIZE_W-1:0] size;
  logic              at_end;

  assign size   = ctl_q[SIZE_W-1:0];
  assign at_end = (cnt_q == size - 1'b1);

  always_comb begin
    st_d = st_q; buf_d = buf_q; ctl_d = ctl_q; nxt_d = nxt_q;
    word_d = word_q; cnt_d = cnt_q; undr_d = undr_q;
    mq = '0; ev = '0;
    tx_valid = 1'b0; tx_last = 1'b0;
    tx_data  = word_q[{cnt_q[1:0], 3'b000} +: 8];
    unique case (st_q)
      T_IDLE: if (en_i) st_d = T_RBUF;
      T_RBUF: begin
        mq.req = 1'b1; mq.addr = ptr_i;
        if (ms.gnt) begin
          buf_d = ms.rdata;
          st_d  = T_RCTL;
        end
      end
      T_RCTL: begin
        mq.req = 1'b1; mq.addr = ptr_i + 32'd4;
        if (ms.gnt && !ms.err) begin
          ctl_d = ms.rdata;
          if (ms.rdata[OWN_BIT]) begin
            ev.halt = 1'b1;
            st_d    = T_IDLE;
          end else st_d = T_RNXT;
        end
      end
      T_RNXT: begin
        mq.req = 1'b1; mq.addr = ptr_i + 32'd8;
        if (ms.gnt) begin
          nxt_d  = ms.rdata;
          cnt_d  = '0;
          undr_d = (size == '0);
          st_d   = (size == '0) ? T_WB : T_FETCH;
        end
      end
      T_FETCH: begin
        mq.req = 1'b1; mq.addr = buf_q + {{(WORD_W-SIZE_W){1'b0}}, cnt_q[SIZE_W-1:2], 2'b00};
        if (ms.gnt) begin
          word_d = ms.rdata;
          st_d   = T_SEND;
        end
      end
      T_SEND: begin
        tx_valid = 1'b1;
        tx_last  = at_end;
        if (tx_ready) begin
          cnt_d = cnt_q + 1'b1;
          if (at_end)                st_d = T_WB;
          else if (cnt_q[1:0] == 2'd3) st_d = T_FETCH;
        end
      end
      T_WB: begin
        mq.req = 1'b1; mq.we = 1'b1; mq.addr = ptr_i + 32'd4;
        mq.wdata = ctl_q | (32'd1 << OWN_BIT);
        if (ms.gnt && !ms.err) begin
          ev.done   = ~undr_q;
          ev.flt    = undr_q;
          ev.ptr_ld = 1'b1;
          ev.ptr_nx = nxt_q;
          st_d      = T_IDLE;
        end
      end
      default: st_d = T_IDLE;
    endcase
    // any failed access ends the descriptor walk
    if (ms.gnt && ms.err) begin
      ev = '0;
      ev.berr = 1'b1;
      ev.halt = 1'b1;
      st_d    = T_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= T_IDLE; buf_q <= '0; ctl_q <= '0; nxt_q <= '0;
      word_q <= '0; cnt_q <= '0; undr_q <= 1'b0;
    end else begin
      st_q <= st_d; buf_q <= buf_d; ctl_q <= ctl_d; nxt_q <= nxt_d;
      word_q <= word_d; cnt_q <= cnt_d; undr_q <= undr_d;
    end
  end

  p_tx_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (cnt_q < size));
  p_tx_handback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mq.req && mq.we) |-> mq.wdata[OWN_BIT]);
  p_tx_no_bytes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == T_WB) |-> !tx_valid);
endmodule

// File: rtl/ring_dma_rx.sv
module ring_dma_rx
  import ring_dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [WORD_W-1:0] ptr_i,
  output mreq_t             mq,
  input  mrsp_t             ms,
  output chev_t             ev,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  output logic              rx_ready
);
  typedef enum logic [2:0] {R_IDLE, R_RBUF, R_RCTL, R_RNXT, R_RECV, R_WR, R_WB} rst_e;

  rst_e              st_q, st_d;
  logic [WORD_W-1:0] buf_q, buf_d, nxt_q, nxt_d, wbuf_q, wbuf_d;
  logic [30:0]       ctl_q, ctl_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SIZE_W-3:0] wofs_q, wofs_d;
  logic              last_q, last_d, ovf_q, ovf_d;
  logic [CNT_W-1:0]  cap;
  logic [SIZE_W-1:0] len;

  assign cap = {{(CNT_W-SIZE_W){1'b0}}, ctl_q[SIZE_W-1:0]};
  assign len = ovf_q ? ctl_q[SIZE_W-1:0] : cnt_q[SIZE_W-1:0];

  always_comb begin
    st_d = st_q; buf_d = buf_q; ctl_d = ctl_q; nxt_d = nxt_q; wbuf_d = wbuf_q;
    cnt_d = cnt_q; wofs_d = wofs_q; last_d = last_q; ovf_d = ovf_q;
    mq = '0; ev = '0; rx_ready = 1'b0;
    unique case (st_q)
      R_IDLE: if (en_i) st_d = R_RBUF;
      R_RBUF: begin
        mq.req = 1'b1; mq.addr = ptr_i;
        if (ms.gnt) begin
          buf_d = ms.rdata;
          st_d  = R_RCTL;
        end
      end
      R_RCTL: begin
        mq.req = 1'b1; mq.addr = ptr_i + 32'd4;
        if (ms.gnt && !ms.err) begin
          ctl_d = ms.rdata[30:0];
          if (!ms.rdata[OWN_BIT]) begin
            ev.halt = 1'b1;
            st_d    = R_IDLE;
          end else st_d = R_RNXT;
        end
      end
      R_RNXT: begin
        mq.req = 1'b1; mq.addr = ptr_i + 32'd8;
        if (ms.gnt) begin
          nxt_d = ms.rdata; cnt_d = '0; wbuf_d = '0;
          ovf_d = 1'b0; last_d = 1'b0;
          st_d  = R_RECV;
        end
      end
      R_RECV: begin
        rx_ready = 1'b1;
        if (rx_valid) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q < cap) begin
            wbuf_d = wbuf_q | ({24'd0, rx_data} << {cnt_q[1:0], 3'b000});
            if (cnt_q[1:0] == 2'd3 || rx_last || cnt_q == cap - 1'b1) begin
              wofs_d = cnt_q[SIZE_W-1:2];
              last_d = rx_last;
              st_d   = R_WR;
            end
          end else begin
            ovf_d = 1'b1;
            if (rx_last) st_d = R_WB;
          end
        end
      end
      R_WR: begin
        mq.req = 1'b1; mq.we = 1'b1;
        mq.addr  = buf_q + {{(WORD_W-SIZE_W){1'b0}}, wofs_q, 2'b00};
        mq.wdata = wbuf_q;
        if (ms.gnt) begin
          wbuf_d = '0;
          st_d   = last_q ? R_WB : R_RECV;
        end
      end
      R_WB: begin
        mq.req = 1'b1; mq.we = 1'b1; mq.addr = ptr_i + 32'd4;
        mq.wdata = {1'b0, ctl_q[30:SIZE_W], len};
        if (ms.gnt && !ms.err) begin
          ev.done   = 1'b1;
          ev.flt    = ovf_q;
          ev.ptr_ld = 1'b1;
          ev.ptr_nx = nxt_q;
          st_d      = R_IDLE;
        end
      end
      default: st_d = R_IDLE;
    endcase
    if (ms.gnt && ms.err) begin
      ev = '0;
      ev.berr = 1'b1;
      ev.halt = 1'b1;
      st_d    = R_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= R_IDLE; buf_q <= '0; ctl_q <= '0; nxt_q <= '0; wbuf_q <= '0;
      cnt_q <= '0; wofs_q <= '0; last_q <= 1'b0; ovf_q <= 1'b0;
    end else begin
      st_q <= st_d; buf_q <= buf_d; ctl_q <= ctl_d; nxt_q <= nxt_d; wbuf_q <= wbuf_d;
      cnt_q <= cnt_d; wofs_q <= wofs_d; last_q <= last_d; ovf_q <= ovf_d;
    end
  end

  p_rx_len_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == R_WB && mq.req) |-> (mq.wdata[SIZE_W-1:0] <= ctl_q[SIZE_W-1:0]));
  p_rx_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == R_WB && mq.req) |-> !mq.wdata[OWN_BIT]);
  p_rx_store_in_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == R_WR && mq.req) |-> ({wofs_q, 2'b00} < ctl_q[SIZE_W-1:0]));
endmodule

// File: rtl/ring_dma.sv
module ring_dma
  import ring_dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RSEL_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_err,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  output logic              rx_ready
);
  localparam logic [3:0] TX_ST_MASK = 4'b1011;
  localparam logic [3:0] RX_ST_MASK = 4'b1101;

  mreq_t tx_mq, rx_mq, bus_q;
  mrsp_t tx_ms, rx_ms, bus_s;
  chev_t tx_ev, rx_ev;

  logic              tx_en_q, tx_en_d, rx_en_q, rx_en_d;
  logic [WORD_W-1:0] tx_ptr_q, tx_ptr_d, rx_ptr_q, rx_ptr_d;
  logic [3:0]        tx_st_q, tx_st_d, rx_st_q, rx_st_d;
  logic [7:0]        ien_q, ien_d, ist;
  reg_sel_e          sel;

  ring_dma_tx u_tx (
    .clk, .rst_n, .en_i(tx_en_q), .ptr_i(tx_ptr_q), .mq(tx_mq), .ms(tx_ms), .ev(tx_ev),
    .tx_valid, .tx_data, .tx_last, .tx_ready
  );

  ring_dma_rx #(.CNT_W(CNT_W)) u_rx (
    .clk, .rst_n, .en_i(rx_en_q), .ptr_i(rx_ptr_q), .mq(rx_mq), .ms(rx_ms), .ev(rx_ev),
    .rx_valid, .rx_data, .rx_last, .rx_ready
  );

  ring_dma_arb u_arb (
    .clk, .rst_n, .tx_q(tx_mq), .rx_q(rx_mq), .tx_s(tx_ms), .rx_s(rx_ms),
    .bus_q, .bus_s
  );

  assign mem_req   = bus_q.req;
  assign mem_we    = bus_q.we;
  assign mem_addr  = bus_q.addr;
  assign mem_wdata = bus_q.wdata;
  assign bus_s     = '{gnt: mem_gnt, err: mem_err, rdata: mem_rdata};

  assign sel = reg_sel_e'(reg_addr);
  assign ist = {rx_st_q[3], rx_st_q[2], 1'b0, rx_st_q[0],
                tx_st_q[3], 1'b0, tx_st_q[1], tx_st_q[0]};
  assign irq = |(ist & ien_q);

  always_comb begin
    tx_en_d = tx_en_q; rx_en_d = rx_en_q; tx_ptr_d = tx_ptr_q; rx_ptr_d = rx_ptr_q;
    ien_d = ien_q;
    tx_st_d = tx_st_q; rx_st_d = rx_st_q;
    // channel link follow, overridden by a software pointer write
    if (tx_ev.ptr_ld) tx_ptr_d = tx_ev.ptr_nx;
    if (rx_ev.ptr_ld) rx_ptr_d = rx_ev.ptr_nx;
    if (reg_we) begin
      unique case (sel)
        RA_TXCTL: tx_en_d  = reg_wdata[0];
        RA_TXPTR: tx_ptr_d = reg_wdata;
        RA_TXST:  tx_st_d  = tx_st_q & ~reg_wdata[3:0];
        RA_RXCTL: rx_en_d  = reg_wdata[0];
        RA_RXPTR: rx_ptr_d = reg_wdata;
        RA_RXST:  rx_st_d  = rx_st_q & ~reg_wdata[3:0];
        RA_IEN:   ien_d    = reg_wdata[7:0];
        default:  ;
      endcase
    end
    // a channel stop wins over a simultaneous enable write
    if (tx_ev.halt) tx_en_d = 1'b0;
    if (rx_ev.halt) rx_en_d = 1'b0;
    tx_st_d = (tx_st_d | {tx_ev.berr, 1'b0, tx_ev.flt, tx_ev.done}) & TX_ST_MASK;
    rx_st_d = (rx_st_d | {rx_ev.berr, rx_ev.flt, 1'b0, rx_ev.done}) & RX_ST_MASK;
  end

  always_comb begin
    unique case (sel)
      RA_TXCTL: reg_rdata = {31'd0, tx_en_q};
      RA_TXPTR: reg_rdata = tx_ptr_q;
      RA_TXST:  reg_rdata = {28'd0, tx_st_q};
      RA_RXCTL: reg_rdata = {31'd0, rx_en_q};
      RA_RXPTR: reg_rdata = rx_ptr_q;
      RA_RXST:  reg_rdata = {28'd0, rx_st_q};
      RA_IEN:   reg_rdata = {24'd0, ien_q};
      default:  reg_rdata = {24'd0, ist};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0; rx_en_q <= 1'b0; tx_ptr_q <= '0; rx_ptr_q <= '0;
      tx_st_q <= '0; rx_st_q <= '0; ien_q <= '0;
    end else begin
      tx_en_q <= tx_en_d; rx_en_q <= rx_en_d; tx_ptr_q <= tx_ptr_d; rx_ptr_q <= rx_ptr_d;
      tx_st_q <= tx_st_d; rx_st_q <= rx_st_d; ien_q <= ien_d;
    end
  end

  p_sticky_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_st_q[0] && !(reg_we && reg_addr == RA_TXST && reg_wdata[0])) |=> tx_st_q[0]);
  p_sticky_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_st_q[2] && !(reg_we && reg_addr == RA_RXST && reg_wdata[2])) |=> rx_st_q[2]);
  p_halt_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ev.halt |=> !tx_en_q);
  p_halt_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ev.halt |=> (!rx_en_q && !rx_ready));
  p_berr_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_gnt && mem_err) |=> (tx_st_q[3] || rx_st_q[3]));
endmodule

// File: tb/sim_ring_dma.sv
module sim_ring_dma;
  logic        clk, rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, mem_req, mem_we, mem_gnt, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_last, tx_ready, rx_valid, rx_last, rx_ready;
  logic [7:0]  tx_data, rx_data;

  int nchk = 0, nerr = 0;

  ring_dma u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // memory model and stall pattern
  logic [31:0] mem [512];
  logic [7:0]  cyc;
  logic        bw_en;
  logic [8:0]  bw_a;
  logic [31:0] bw_d;

  assign mem_gnt   = mem_req && (cyc[1:0] != 2'd3);
  assign mem_err   = mem_gnt && (mem_addr[31:11] != 21'd0);
  assign mem_rdata = mem[mem_addr[10:2]];
  assign tx_ready  = (cyc[2:0] != 3'd5);

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0; else cyc <= cyc + 8'd1;
    if (bw_en) mem[bw_a] <= bw_d;
    else if (mem_gnt && mem_we && !mem_err) mem[mem_addr[10:2]] <= mem_wdata;
  end

  // transmit sink
  logic [7:0] txb [32];
  logic       txl [32];
  int         txn;
  logic       txclr;
  always_ff @(posedge clk) begin
    if (txclr) txn <= 0;
    else if (tx_valid && tx_ready) begin
      txb[txn[4:0]] <= tx_data;
      txl[txn[4:0]] <= tx_last;
      txn <= txn + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic mem_put(input logic [31:0] byte_addr, input logic [31:0] d);
    @(negedge clk); bw_en = 1'b1; bw_a = byte_addr[10:2]; bw_d = d;
    @(negedge clk); bw_en = 1'b0;
  endtask

  task automatic wait_bits(input logic [2:0] a, input logic [31:0] mask, input logic [31:0] want);
    logic [31:0] d;
    for (int n = 0; n < 4000; n++) begin
      reg_rd(a, d);
      if ((d & mask) == want) break;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic l);
    logic ok;
    @(negedge clk); rx_valid = 1'b1; rx_data = b; rx_last = l;
    forever begin
      ok = rx_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int k);
    return 8'((i * 37 + k * 13 + 1) & 255);
  endfunction

  // capacity, frame length
  localparam int NV = 6;
  localparam int VT [NV][2] = '{'{16, 8}, '{16, 16}, '{16, 5}, '{8, 13}, '{7, 10}, '{12, 1}};

  initial begin
    #1_000_000;
    nerr++; nchk++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    reg_we = 0; reg_addr = 0; reg_wdata = 0; bw_en = 0; bw_a = 0; bw_d = 0;
    rx_valid = 0; rx_data = 0; rx_last = 0; txclr = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); txclr = 0;

    // R13 reset state
    for (int a = 0; a < 8; a++) begin
      reg_rd(3'(a), d);
      check("R13 register after reset", d, 32'd0);
    end
    check("R13 outputs idle", {31'd0, irq | mem_req | tx_valid | rx_ready}, 32'd0);

    // R4 R7 R1 receive vector table on a self-linked descriptor
    for (int i = 0; i < NV; i++) begin
      int cap = VT[i][0];
      int len = VT[i][1];
      int wl  = (len < cap) ? len : cap;
      for (int w = 0; w < 16; w++) mem_put(32'h200 + 32'(w * 4), 32'hEEEE_EEEE);
      mem_put(32'h40, 32'h200);
      mem_put(32'h44, 32'h8015_0000 | 32'(cap));
      mem_put(32'h48, 32'h40);
      reg_wr(3'd4, 32'h40);
      reg_wr(3'd3, 32'd1);
      for (int k = 0; k < len; k++) send_byte(pat(i, k), k == len - 1);
      @(negedge clk); rx_valid = 0; rx_last = 0;
      wait_bits(3'd5, 32'h1, 32'h1);
      check("R4 R7 written-back control word", mem[9'h44 >> 2], 32'h0015_0000 | 32'(wl));
      for (int w = 0; w < 16; w++) begin
        logic [31:0] e;
        if (w * 4 >= wl) e = 32'hEEEE_EEEE;
        else begin
          e = '0;
          for (int b = 0; b < 4; b++)
            if (w * 4 + b < wl) e[b*8 +: 8] = pat(i, w * 4 + b);
        end
        check("R4 R7 R1 buffer word", mem[9'((32'h200 >> 2) + w)], e);
      end
      reg_rd(3'd5, d);
      check("R7 overflow flag", d, (len > cap) ? 32'h5 : 32'h1);
      reg_rd(3'd7, d);
      check("R11 summary mirrors receive status", d, (len > cap) ? 32'h50 : 32'h10);
      repeat (12) @(negedge clk);
      reg_rd(3'd3, d);
      check("R5 stop on owned-by-software descriptor", d, 32'd0);
      check("R5 rx_ready low after stop", {31'd0, rx_ready}, 32'd0);
      reg_rd(3'd4, d);
      check("R6 receive pointer follows link", d, 32'h40);
      reg_wr(3'd5, 32'h0);
      reg_rd(3'd5, d);
      check("R10 write of zero keeps status", d, (len > cap) ? 32'h5 : 32'h1);
      reg_wr(3'd5, 32'hF);
      reg_rd(3'd5, d);
      check("R10 write-one clears status", d, 32'd0);
    end

    // R2 R3 R6 transmit chain of two descriptors then a returned one
    mem_put(32'h100, 32'h4433_2211);
    mem_put(32'h104, 32'h0000_6655);
    mem_put(32'h120, 32'h00CC_BBAA);
    mem_put(32'h000, 32'h100); mem_put(32'h004, 32'h0015_0006); mem_put(32'h008, 32'h00C);
    mem_put(32'h00C, 32'h120); mem_put(32'h010, 32'h0000_0003); mem_put(32'h014, 32'h018);
    mem_put(32'h018, 32'h140); mem_put(32'h01C, 32'h8000_0004); mem_put(32'h020, 32'h024);
    reg_wr(3'd1, 32'h0);
    reg_wr(3'd0, 32'd1);
    wait_bits(3'd0, 32'h1, 32'h0);
    check("R2 R3 byte count across chain", 32'(txn), 32'd9);
    begin
      logic [7:0] eb [9] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'hAA, 8'hBB, 8'hCC};
      for (int k = 0; k < 9; k++) begin
        check("R2 transmitted byte", {24'd0, txb[k]}, {24'd0, eb[k]});
        check("R2 last marker", {31'd0, txl[k]}, {31'd0, (k == 5 || k == 8)});
      end
    end
    check("R2 first descriptor handed back", mem[1], 32'h8015_0006);
    check("R2 second descriptor handed back", mem[4], 32'h8000_0003);
    reg_rd(3'd1, d);
    check("R6 transmit pointer at third descriptor", d, 32'h18);
    reg_rd(3'd2, d);
    check("R2 sent status", d, 32'h1);
    reg_rd(3'd0, d);
    check("R3 enable cleared at owned descriptor", d, 32'd0);
    reg_wr(3'd2, 32'hF);

    // R8 size zero descriptor
    @(negedge clk); txclr = 1; @(negedge clk); txclr = 0;
    mem_put(32'h024, 32'h140); mem_put(32'h028, 32'h0000_0000); mem_put(32'h02C, 32'h030);
    mem_put(32'h034, 32'h8000_0000);
    reg_wr(3'd1, 32'h24);
    reg_wr(3'd0, 32'd1);
    wait_bits(3'd0, 32'h1, 32'h0);
    check("R8 no bytes sent", 32'(txn), 32'd0);
    reg_rd(3'd2, d);
    check("R8 underrun status only", d, 32'h2);
    check("R8 descriptor handed back", mem[10], 32'h8000_0000);
    reg_rd(3'd1, d);
    check("R8 link followed", d, 32'h30);
    reg_wr(3'd2, 32'hF);

    // R9 bus error, R11 interrupt gating
    reg_wr(3'd1, 32'h1000);
    reg_wr(3'd0, 32'd1);
    wait_bits(3'd0, 32'h1, 32'h0);
    reg_rd(3'd2, d);
    check("R9 bus error status", d, 32'h8);
    check("R11 irq low without enable", {31'd0, irq}, 32'd0);
    reg_wr(3'd6, 32'h80);
    check("R11 irq low with other enable", {31'd0, irq}, 32'd0);
    reg_wr(3'd6, 32'h08);
    check("R11 irq high with matching enable", {31'd0, irq}, 32'd1);
    reg_wr(3'd2, 32'h8);
    check("R10 R11 irq drops after clear", {31'd0, irq}, 32'd0);

    // R5 receive descriptor not owned
    mem_put(32'h4C, 32'h300); mem_put(32'h50, 32'h0000_0010); mem_put(32'h54, 32'h4C);
    reg_wr(3'd4, 32'h4C);
    reg_wr(3'd3, 32'd1);
    repeat (20) @(negedge clk);
    reg_rd(3'd3, d);
    check("R5 enable cleared", d, 32'd0);
    reg_rd(3'd5, d);
    check("R5 no status", d, 32'd0);
    check("R5 rx_ready low", {31'd0, rx_ready}, 32'd0);

    // R12 request holds during a stall is checked by the arbiter property
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule